// File: doc/BRIEF.md
# Serial Port Register Front End with Interrupt Logic

This block is the bus-facing register file of a serial port. A processor reaches it through a simple word-addressed port: one cycle carries the byte address, a write or read strobe and 32 bits of write data, and read data comes back from a register one cycle later. The block holds the baud divisor, line, control, FIFO-level and DMA configuration words. It holds a latched copy of the queue status flags, which software can read but not write. It also returns a fixed set of identification bytes from the last 32 bytes of its 4 KB window.

The block does not move serial data itself. A write to the data word becomes a one-cycle transmit push strobe that carries the low byte. A read of the data word returns the receive queue head and gives a one-cycle pop strobe. The interrupt section keeps a raw status vector, an enable mask and a write-one-to-clear path. Its single level-sensitive interrupt line is high while any enabled raw bit is set.

Top module: `uart_regbank`

## Requirements
- R1: After reset, reads return 0x12 at word 13, 0x300 at word 12, 0x90 at word 6 and zero at every other word from 0 to 18 (with rx_data at zero), and irq, rx_pop and tx_push are low.
- R2: Configuration words keep the low bits of the written data and return them zero-extended: word 8 keeps 8 bits, word 9 keeps 16, word 10 keeps 6, word 11 keeps 8, word 12 keeps 16, word 13 keeps 6, word 14 (interrupt mask) keeps 11 and word 18 keeps 3.
- R3: Word 6 reads the status inputs as registered one cycle earlier: tx_empty at bit 7, rx_full at bit 6, tx_full at bit 5, rx_empty at bit 4. Writes to word 6 change nothing.
- R4: A write to word 0 raises tx_push for exactly the next cycle, with tx_byte equal to the written bits 7:0, and it sets raw status bit 5.
- R5: A read of word 0 returns rx_data zero-extended and raises rx_pop for exactly the next cycle. Reads of any other offset never raise rx_pop.
- R6: A high rx_set sets raw status bit 4. In the same cycle this set wins over a clear of that bit.
- R7: A write to word 17 clears each raw status bit whose written bit is 1 and leaves the other raw bits unchanged.
- R8: Word 15 reads the 11-bit raw status. Word 16 reads the raw status ANDed with the mask. Writes to words 15 and 16 change nothing.
- R9: irq is high, from the cycle after any change to raw status or mask, exactly when the raw status ANDed with the mask is nonzero.
- R10: A read at byte offsets 0xFE0 to 0xFFF returns one byte per word, selected by address bits 4:2, in the order 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, with bits 31:8 zero.
- R11: Reads of words 1 to 5, 7 and 19 up to the identification window return zero. Writes to those words change no register.
- R12: When bus_wr and bus_rd are both high, only the write takes place: bus_rdata keeps its value and rx_pop stays low.
- R13: bus_rdata changes only in the cycle after a read and otherwise holds the last value read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_data | input | 12 | Head entry of the receive queue |
| rx_set | input | 1 | Receive event, sets raw status bit 4 |
| rx_empty | input | 1 | Receive queue empty |
| rx_full | input | 1 | Receive queue full |
| tx_empty | input | 1 | Transmit queue empty |
| tx_full | input | 1 | Transmit queue full |
| rx_pop | output | 1 | One-cycle pop request to the receive queue |
| tx_push | output | 1 | One-cycle push request to the transmit queue |
| tx_byte | output | 8 | Byte carried with tx_push |
| irq | output | 1 | Level interrupt: any enabled raw bit set |

## Verification
Every result has one cycle of latency. Read data, the two strobes and the new raw and mask values are all registered at the edge that samples the bus request, so irq and bus_rdata are due one edge after the request and stay there until the next request. Status flags pass through one register, so the bench holds them steady for two edges before it reads word 6. The bench drives inputs on falling edges and samples at the next falling edge, which lies half a period after the edge that updated the outputs. It then samples once more a cycle later to confirm that each strobe lasts exactly one cycle.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int WORD_W  = ADDR_W - 2;
    localparam int INT_W   = 11;
    localparam int RXD_W   = 12;
    localparam int TXD_W   = 8;
    localparam int NUM_SEL = 19;

    localparam int W_LPDIV = 8;
    localparam int W_IBAUD = 16;
    localparam int W_FBAUD = 6;
    localparam int W_LINE  = 8;
    localparam int W_CTRL  = 16;
    localparam int W_LVL   = 6;
    localparam int W_DMA   = 3;

    localparam int IDX_DATA  = 0;
    localparam int IDX_FLAG  = 6;
    localparam int IDX_LPDIV = 8;
    localparam int IDX_IBAUD = 9;
    localparam int IDX_FBAUD = 10;
    localparam int IDX_LINE  = 11;
    localparam int IDX_CTRL  = 12;
    localparam int IDX_LVL   = 13;
    localparam int IDX_MASK  = 14;
    localparam int IDX_RAW   = 15;
    localparam int IDX_MSKD  = 16;
    localparam int IDX_CLR   = 17;
    localparam int IDX_DMA   = 18;

    localparam int ID_BASE = 'hFE0;
    localparam int BIT_TX  = 5;
    localparam int BIT_RX  = 4;

    typedef struct packed {
        logic [W_LPDIV-1:0] lpdiv;
        logic [W_IBAUD-1:0] ibaud;
        logic [W_FBAUD-1:0] fbaud;
        logic [W_LINE-1:0]  line;
        logic [W_CTRL-1:0]  ctrl;
        logic [W_LVL-1:0]   lvl;
        logic [W_DMA-1:0]   dma;
    } cfg_t;

    localparam cfg_t CFG_RST = '{lpdiv: '0, ibaud: '0, fbaud: '0, line: '0,
                                 ctrl: W_CTRL'('h300), lvl: W_LVL'('h12), dma: '0};
    localparam logic [7:0] FLAGS_RST = 8'h90;

    function automatic logic [7:0] id_byte(input logic [2:0] k);
        case (k)
            3'd0:    return 8'h11;
            3'd1:    return 8'h10;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/uart_addr_decode.sv
module uart_addr_decode
    import uart_regbank_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_SEL-1:0] sel,
    output logic               id_hit,
    output logic [2:0]         id_idx
);
    logic [WORD_W-1:0] word;
    logic              unused_lo;

    assign word      = addr[ADDR_W-1:2];
    assign unused_lo = ^addr[1:0];

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        assign sel[i] = (word == WORD_W'(i));
    end

    assign id_hit = (addr >= ADDR_W'(ID_BASE));
    assign id_idx = addr[4:2];
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic [INT_W-1:0] mask_wd,
    input  logic             clr_we,
    input  logic [INT_W-1:0] clr_wd,
    input  logic [INT_W-1:0] set_vec,
    output logic [INT_W-1:0] raw,
    output logic [INT_W-1:0] mask,
    output logic             irq
);
    typedef struct packed {
        logic [INT_W-1:0] raw;
        logic [INT_W-1:0] mask;
    } ist_t;

    ist_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (mask_we) s_d.mask = mask_wd;
        s_d.raw = (s_q.raw & ~(clr_we ? clr_wd : '0)) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign raw  = s_q.raw;
    assign mask = s_q.mask;
    assign irq  = |(s_q.raw & s_q.mask);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [RXD_W-1:0]  rx_data,
    input  logic              rx_set,
    input  logic              rx_empty,
    input  logic              rx_full,
    input  logic              tx_empty,
    input  logic              tx_full,
    output logic              rx_pop,
    output logic              tx_push,
    output logic [TXD_W-1:0]  tx_byte,
    output logic              irq
);
    typedef struct packed {
        cfg_t              cfg;
        logic [7:0]        flags;
        logic [DATA_W-1:0] rdata;
        logic              pop;
        logic              push;
        logic [TXD_W-1:0]  byte_out;
    } st_t;

    st_t s_d, s_q;

    logic [NUM_SEL-1:0] sel;
    logic               id_hit;
    logic [2:0]         id_idx;
    logic               wr, rd;
    logic [INT_W-1:0]   raw, mask, set_vec;
    logic [DATA_W-1:0]  rd_val;
    logic               unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:16];

    uart_addr_decode u_dec (
        .addr   (bus_addr),
        .sel    (sel),
        .id_hit (id_hit),
        .id_idx (id_idx)
    );

    assign wr = bus_wr;
    assign rd = bus_rd & ~bus_wr;

    always_comb begin
        set_vec         = '0;
        set_vec[BIT_TX] = wr & sel[IDX_DATA];
        set_vec[BIT_RX] = rx_set;
    end

    uart_irq_ctrl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (wr & sel[IDX_MASK]),
        .mask_wd (bus_wdata[INT_W-1:0]),
        .clr_we  (wr & sel[IDX_CLR]),
        .clr_wd  (bus_wdata[INT_W-1:0]),
        .set_vec (set_vec),
        .raw     (raw),
        .mask    (mask),
        .irq     (irq)
    );

    always_comb begin
        rd_val = '0;
        if (id_hit)                rd_val = DATA_W'(id_byte(id_idx));
        else if (sel[IDX_DATA])    rd_val = DATA_W'(rx_data);
        else if (sel[IDX_FLAG])    rd_val = DATA_W'(s_q.flags);
        else if (sel[IDX_LPDIV])   rd_val = DATA_W'(s_q.cfg.lpdiv);
        else if (sel[IDX_IBAUD])   rd_val = DATA_W'(s_q.cfg.ibaud);
        else if (sel[IDX_FBAUD])   rd_val = DATA_W'(s_q.cfg.fbaud);
        else if (sel[IDX_LINE])    rd_val = DATA_W'(s_q.cfg.line);
        else if (sel[IDX_CTRL])    rd_val = DATA_W'(s_q.cfg.ctrl);
        else if (sel[IDX_LVL])     rd_val = DATA_W'(s_q.cfg.lvl);
        else if (sel[IDX_MASK])    rd_val = DATA_W'(mask);
        else if (sel[IDX_RAW])     rd_val = DATA_W'(raw);
        else if (sel[IDX_MSKD])    rd_val = DATA_W'(raw & mask);
        else if (sel[IDX_DMA])     rd_val = DATA_W'(s_q.cfg.dma);
    end

    always_comb begin
        s_d       = s_q;
        s_d.pop   = 1'b0;
        s_d.push  = 1'b0;
        s_d.flags = {tx_empty, rx_full, tx_full, rx_empty, 4'b0000};
        if (wr) begin
            if (sel[IDX_DATA]) begin
                s_d.push     = 1'b1;
                s_d.byte_out = bus_wdata[TXD_W-1:0];
            end
            if (sel[IDX_LPDIV]) s_d.cfg.lpdiv = bus_wdata[W_LPDIV-1:0];
            if (sel[IDX_IBAUD]) s_d.cfg.ibaud = bus_wdata[W_IBAUD-1:0];
            if (sel[IDX_FBAUD]) s_d.cfg.fbaud = bus_wdata[W_FBAUD-1:0];
            if (sel[IDX_LINE])  s_d.cfg.line  = bus_wdata[W_LINE-1:0];
            if (sel[IDX_CTRL])  s_d.cfg.ctrl  = bus_wdata[W_CTRL-1:0];
            if (sel[IDX_LVL])   s_d.cfg.lvl   = bus_wdata[W_LVL-1:0];
            if (sel[IDX_DMA])   s_d.cfg.dma   = bus_wdata[W_DMA-1:0];
        end
        if (rd) begin
            s_d.rdata = rd_val;
            s_d.pop   = sel[IDX_DATA] & ~id_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cfg      <= CFG_RST;
            s_q.flags    <= FLAGS_RST;
            s_q.rdata    <= '0;
            s_q.pop      <= 1'b0;
            s_q.push     <= 1'b0;
            s_q.byte_out <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;
    assign rx_pop    = s_q.pop;
    assign tx_push   = s_q.push;
    assign tx_byte   = s_q.byte_out;
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk
    import uart_regbank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rx_set,
    input logic              rx_pop,
    input logic              tx_push,
    input logic [TXD_W-1:0]  tx_byte,
    input logic              irq
);
    logic [WORD_W-1:0] w;
    logic              rd_only, in_id, unmapped;
    logic              unused_bits;

    assign w        = bus_addr[ADDR_W-1:2];
    assign rd_only  = bus_rd && !bus_wr;
    assign in_id    = bus_addr >= ADDR_W'(ID_BASE);
    assign unmapped = !in_id && ((w >= WORD_W'(1) && w <= WORD_W'(5)) || w == WORD_W'(7)
                                 || w >= WORD_W'(NUM_SEL));
    assign unused_bits = ^bus_wdata[DATA_W-1:INT_W];

    AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w == WORD_W'(IDX_DATA)) |=> (tx_push && tx_byte == $past(bus_wdata[TXD_W-1:0]))); // R4
    AST_TX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> $past(bus_wr && w == WORD_W'(IDX_DATA))); // R4
    AST_POP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && w == WORD_W'(IDX_DATA)) |=> rx_pop); // R5
    AST_POP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> $past(rd_only && w == WORD_W'(IDX_DATA))); // R5
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w == WORD_W'(IDX_CLR) && bus_wdata[INT_W-1:0] == '1 && !rx_set) |=> !irq); // R7
    AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w == WORD_W'(IDX_MASK) && bus_wdata[INT_W-1:0] == '0) |=> !irq); // R9
    AST_ID_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && in_id) |=> (bus_rdata[DATA_W-1:8] == '0)); // R10
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && unmapped) |=> (bus_rdata == '0)); // R11
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_wr) |=> ($stable(bus_rdata) && !rx_pop)); // R12
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_only |=> $stable(bus_rdata)); // R13
endmodule

bind uart_regbank uart_regbank_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rx_set    (rx_set),
    .rx_pop    (rx_pop),
    .tx_push   (tx_push),
    .tx_byte   (tx_byte),
    .irq       (irq)
);

// File: tb/uart_regbank_test.sv
`timescale 1ns/1ps
module uart_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] rx_data = '0;
    logic        rx_set = 1'b0;
    logic        rx_empty = 1'b1, rx_full = 1'b0, tx_empty = 1'b1, tx_full = 1'b0;
    logic        rx_pop, tx_push, irq;
    logic [7:0]  tx_byte;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_regbank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_data(rx_data), .rx_set(rx_set),
        .rx_empty(rx_empty), .rx_full(rx_full), .tx_empty(tx_empty), .tx_full(tx_full),
        .rx_pop(rx_pop), .tx_push(tx_push), .tx_byte(tx_byte), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int word, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 12'(word * 4); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int byte_addr, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 12'(byte_addr); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] cfg_exp(input int w, input logic [31:0] p);
        case (w)
            8:  return p & 32'hFF;
            9:  return p & 32'hFFFF;
            10: return p & 32'h3F;
            11: return p & 32'hFF;
            12: return p & 32'hFFFF;
            13: return p & 32'h3F;
            14: return p & 32'h7FF;
            18: return p & 32'h7;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [7:0] id_exp(input int k);
        case (k)
            0: return 8'h11; 1: return 8'h10; 2: return 8'h14; 3: return 8'h00;
            4: return 8'h0D; 5: return 8'hF0; 6: return 8'h05; default: return 8'hB1;
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d, m_exp;
        logic [31:0] pats[3];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_A5A5; pats[2] = 32'h5A5A_5A5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 tx_push", 32'(tx_push), 0);
        chk("R1 rx_pop", 32'(rx_pop), 0);
        for (int w = 0; w < 19; w++) begin
            rd(w * 4, d);
            chk("R1 reset word", d, (w == 12) ? 32'h300 : (w == 13) ? 32'h12 : (w == 6) ? 32'h90 : 32'h0);
        end

        // R2 / R8 / R11 write sweep over words 1..31, data word skipped
        foreach (pats[pi]) begin
            for (int w = 1; w < 32; w++) wr(w, pats[pi]);
            for (int w = 1; w < 32; w++) begin
                rd(w * 4, d);
                if (w == 6)       chk("R3 flag write ignored", d, 32'h90);
                else if (w == 15) chk("R8 raw write ignored", d, 0);
                else if (w == 16) chk("R8 masked write ignored", d, 0);
                else if (w == 14 || (w >= 8 && w <= 13) || w == 18)
                                  chk("R2 readback", d, cfg_exp(w, pats[pi]));
                else              chk("R11 unmapped", d, 0);
            end
            chk("R9 irq without raw", 32'(irq), 0);
        end

        // R11 unmapped reads up to the id window
        for (int w = 19; w < 1016; w++) begin
            rd(w * 4, d);
            chk("R11 unmapped read", d, 0);
        end

        // R10 identification bytes
        for (int k = 0; k < 8; k++) begin
            rd(12'hFE0 + k * 4, d);
            chk("R10 id byte", d, 32'(id_exp(k)));
        end

        // R3 status flags
        for (int s = 0; s < 16; s++) begin
            @(negedge clk);
            {tx_empty, rx_full, tx_full, rx_empty} = 4'(s);
            @(negedge clk);
            rd(6 * 4, d);
            chk("R3 flags", d, 32'(s) << 4);
        end
        {tx_empty, rx_full, tx_full, rx_empty} = 4'b1001;

        // R4 transmit push
        wr(14, 0);
        wr(17, 32'h7FF);
        for (int v = 0; v < 256; v += 37) begin
            wr(0, 32'hABCD_0000 | 32'(v));
            chk("R4 tx_push", 32'(tx_push), 1);
            chk("R4 tx_byte", 32'(tx_byte), 32'(v));
            @(negedge clk);
            chk("R4 tx_push one cycle", 32'(tx_push), 0);
        end
        rd(15 * 4, d);
        chk("R4 raw tx bit", d, 32'h20);

        // R5 / R13 receive pop
        for (int k = 0; k < 3; k++) begin
            rx_data = (k == 0) ? 12'h041 : (k == 1) ? 12'h400 : 12'hFFF;
            rd(0, d);
            chk("R5 rx data", d, 32'(rx_data));
            chk("R5 rx_pop", 32'(rx_pop), 1);
            @(negedge clk);
            chk("R5 rx_pop one cycle", 32'(rx_pop), 0);
            chk("R13 rdata held", bus_rdata, 32'(rx_data));
        end
        rd(9 * 4, d);
        chk("R5 no pop elsewhere", 32'(rx_pop), 0);

        // R7 / R8 / R9 mask sweep
        for (int m = 0; m < 2048; m++) begin
            wr(14, 32'(m));
            wr(17, 32'h7FF);
            chk("R7 clear all", 32'(irq), 0);
            wr(0, 32'h55);
            chk("R9 irq tx", 32'(irq), 32'((m >> 5) & 1));
            @(negedge clk); rx_set = 1'b1;
            @(negedge clk); rx_set = 1'b0;
            m_exp = 32'(m) & 32'h30;
            chk("R9 irq tx+rx", 32'(irq), 32'(m_exp != 0));
            rd(16 * 4, d);
            chk("R8 masked", d, m_exp);
            rd(15 * 4, d);
            chk("R8 raw", d, 32'h30);
            wr(17, 32'h20);
            chk("R7 partial clear", 32'(irq), 32'((m >> 4) & 1));
        end

        // R6 set beats clear
        wr(17, 32'h7FF);
        @(negedge clk);
        bus_addr = 12'(17 * 4); bus_wdata = 32'h10; bus_wr = 1'b1; rx_set = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; rx_set = 1'b0;
        rd(15 * 4, d);
        chk("R6 set wins", d, 32'h10);

        // R12 write and read together
        rx_data = 12'h123;
        rd(9 * 4, d);
        @(negedge clk);
        bus_addr = 0; bus_wdata = 32'h77; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R12 tx_push", 32'(tx_push), 1);
        chk("R12 no pop", 32'(rx_pop), 0);
        chk("R12 rdata held", bus_rdata, d);

        finish_run();
    end
endmodule